// File: doc/BRIEF.md
# Multiplexed segment LCD drive sequencer

This block produces the time-multiplexed drive pattern for a segment LCD with four common lines and a parameterised number of segment lines. It steps the commons through their phases at one of three duties, with the phase length picked from four rates. At the start of every common phase it opens a short key-scan slot. In that slot the first few segment lines strobe in turn as key sources and every common rests at mid level. For every pin it emits a symbolic 3-bit level code. Analog buffers outside the block turn that code into a voltage.

The display contents come from a four-row latch, one row per common phase, presented on a flat input bus. The top few segment lines can be switched into LED mode. In that mode they give up multiplexing and show row 0 with inverted polarity. The drive polarity alternates on every frame, so the time-averaged voltage across each pixel is zero. Clearing the output enable or the display-on flag forces every pin to the full level, which blanks the panel.

Top module: `lcdmux_drive_seq`

## Requirements
- R1: After reset, and at the clock edge that first sees a new duty or rate selection, the sequence restarts at phase 0, at the first clock of the key-scan slot, with positive polarity.
- R2: One clock is one oscillator period. A phase lasts BASE_DIV << rate_sel clocks. The frame holds 4 phases for duty_sel 00, 3 phases for 01, and 2 phases for 10 or 11. A common above the used count is never selected.
- R3: The key-scan slot is the first KEY_SLOT clocks of each phase. In the slot every common drives code 2. Key source k (segment k, k < KEY_SRCS) drives code 4 during clocks k*S to k*S+S-1 of the slot, where S = KEY_SLOT/KEY_SRCS, and code 0 otherwise. Every other segment in LCD mode drives code 0.
- R4: Outside the slot, the common of the current phase drives code 4 in a positive frame and code 0 in a negative frame. Non-selected commons drive code 2 at half bias (duty_sel 1x). At one-third bias (duty_sel 0x) they drive code 1 in a positive frame and code 3 in a negative frame.
- R5: Outside the slot, a segment takes its bit from row p of the latch (bit p*SEG_COUNT+i for segment i) in phase p. A 1 drives code 0 in a positive frame and code 4 in a negative frame. A 0 at half bias drives code 4 (positive) or code 0 (negative). A 0 at one-third bias drives code 3 (positive) or code 1 (negative).
- R6: Polarity begins positive and inverts at each frame boundary.
- R7: With led_mode high, the top LED_COUNT segment pins show row 0 statically in every clock, including the key slot. A bit of 0 drives code 0 (LED on) and a bit of 1 drives code 4 (LED off).
- R8: While out_en or disp_on is low, every common and segment pin drives code 4. Timing continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one tick per period |
| rst_n | input | 1 | Synchronous active-low reset |
| duty_sel | input | 2 | Duty and bias selection |
| rate_sel | input | 2 | Phase length selection |
| disp_on | input | 1 | Display on; low blanks the panel |
| out_en | input | 1 | Output enable; low blanks the panel |
| led_mode | input | 1 | Top segment pins act as LED outputs |
| latch_bits | input | 4*SEG_COUNT | Display rows, row r at bits r*SEG_COUNT upward |
| com_lvl | output | 12 | Level code per common, common i at bits 3i+2:3i |
| seg_lvl | output | 3*SEG_COUNT | Level code per segment, segment i at bits 3i+2:3i |

## Verification
The bench builds the block with SEG_COUNT 16, KEY_SRCS 4, LED_COUNT 4, KEY_SLOT 8 and BASE_DIV 32. These values shrink a phase to 32 to 256 clocks and a key strobe to 2 clocks. All sixteen duty and rate combinations can then run through two whole frames and into a third. That covers every phase, both polarities, each key strobe and the restart when a selection changes in mid-frame. Random latch rows, LED mode on some runs and blanking windows inside frames are mixed in. Pins sit at the boundary between the LED group and the key-source group, and are checked in every clock.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;

   localparam int COM_COUNT = 4;

   typedef enum logic [2:0] {
      LVL_GND        = 3'd0,
      LVL_THIRD      = 3'd1,
      LVL_HALF       = 3'd2,
      LVL_TWO_THIRDS = 3'd3,
      LVL_FULL       = 3'd4
   } drv_lvl_e;

   // index of the last common phase for a duty selection
   function automatic logic [1:0] last_phase(input logic [1:0] duty);
      case (duty)
         2'b00:   return 2'd3;
         2'b01:   return 2'd2;
         default: return 2'd1;
      endcase
   endfunction

   // multiplexed segment level outside the key slot
   function automatic drv_lvl_e seg_level(input logic lit, input logic neg,
                                          input logic third);
      if (lit)        return neg ? LVL_FULL  : LVL_GND;
      else if (third) return neg ? LVL_THIRD : LVL_TWO_THIRDS;
      else            return neg ? LVL_GND   : LVL_FULL;
   endfunction

endpackage

// File: rtl/lcdseq_timer.sv
module lcdseq_timer
   import lcdseq_pkg::*;
#(
   parameter int BASE_DIV = 128,
   parameter int KEY_SLOT = 16,
   parameter int KEY_SRCS = 8,
   parameter int KIW      = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [1:0]     duty_sel,
   input  logic [1:0]     rate_sel,
   output logic [1:0]     phase,
   output logic           neg_pol,
   output logic           in_key,
   output logic [KIW-1:0] key_idx
);

   localparam int MAXLEN = BASE_DIV * 8;
   localparam int CW     = $clog2(MAXLEN);
   localparam int STROBE = KEY_SLOT / KEY_SRCS;

   logic [CW-1:0] cnt;
   logic [CW-1:0] last_cnt;
   logic [1:0]    last_ph;
   logic [3:0]    mode_q;
   logic          restart;
   logic          frame_end;

   always_comb begin
      last_cnt  = CW'(BASE_DIV * (1 << rate_sel) - 1);
      last_ph   = last_phase(duty_sel);
      restart   = ({duty_sel, rate_sel} != mode_q);
      frame_end = (cnt == last_cnt) && (phase == last_ph);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         phase   <= '0;
         neg_pol <= 1'b0;
         mode_q  <= '0;
      end else if (restart) begin
         cnt     <= '0;
         phase   <= '0;
         neg_pol <= 1'b0;
         mode_q  <= {duty_sel, rate_sel};
      end else if (cnt == last_cnt) begin
         cnt <= '0;
         if (phase == last_ph) begin
            phase   <= '0;
            neg_pol <= ~neg_pol;
         end else begin
            phase <= phase + 2'd1;
         end
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   always_comb begin
      in_key  = (cnt < CW'(KEY_SLOT));
      key_idx = KIW'(cnt / CW'(STROBE));
   end

   AST_CNT_BOUND:   assert property (@(posedge clk) disable iff (!rst_n)
                       !restart |-> cnt <= last_cnt);                      // R2
   AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
                       !restart |-> phase <= last_ph);                     // R2
   AST_RESTART:     assert property (@(posedge clk) disable iff (!rst_n)
                       restart |=> (cnt == '0 && phase == 2'd0 && !neg_pol)); // R1
   AST_POL_FLIP:    assert property (@(posedge clk) disable iff (!rst_n)
                       (!restart && frame_end) |=> neg_pol != $past(neg_pol)); // R6
   AST_POL_HOLD:    assert property (@(posedge clk) disable iff (!rst_n)
                       (!restart && !frame_end) |=> $stable(neg_pol));    // R6

endmodule

// File: rtl/lcdseq_com.sv
module lcdseq_com
   import lcdseq_pkg::*;
(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             phase,
   input  logic                   neg_pol,
   input  logic                   in_key,
   input  logic                   third_bias,
   input  logic                   blank,
   output logic [3*COM_COUNT-1:0] com_lvl
);

   logic [COM_COUNT-1:0] driven_hard;

   for (genvar i = 0; i < COM_COUNT; i++) begin : g_com
      drv_lvl_e lvl;
      always_comb begin
         if (blank)                lvl = LVL_FULL;
         else if (in_key)          lvl = LVL_HALF;
         else if (phase == 2'(i))  lvl = neg_pol ? LVL_GND : LVL_FULL;
         else if (third_bias)      lvl = neg_pol ? LVL_TWO_THIRDS : LVL_THIRD;
         else                      lvl = LVL_HALF;
      end
      assign com_lvl[3*i +: 3] = lvl;
      assign driven_hard[i] = (com_lvl[3*i +: 3] == LVL_FULL) ||
                              (com_lvl[3*i +: 3] == LVL_GND);
   end

   AST_ONE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
                        (!blank && !in_key) |-> $countones(driven_hard) == 1); // R4

endmodule

// File: rtl/lcdseq_seg.sv
module lcdseq_seg
   import lcdseq_pkg::*;
#(
   parameter int SEG_COUNT = 56,
   parameter int KEY_SRCS  = 8,
   parameter int LED_COUNT = 8,
   parameter int KIW       = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [SEG_COUNT-1:0]   row_bits,
   input  logic [LED_COUNT-1:0]   led_bits,
   input  logic                   neg_pol,
   input  logic                   in_key,
   input  logic [KIW-1:0]         key_idx,
   input  logic                   third_bias,
   input  logic                   blank,
   input  logic                   led_mode,
   output logic [3*SEG_COUNT-1:0] seg_lvl
);

   localparam int LED_BASE = SEG_COUNT - LED_COUNT;

   logic [KEY_SRCS-1:0] ks_high;

   for (genvar i = 0; i < SEG_COUNT; i++) begin : g_seg
      drv_lvl_e lvl;
      logic     strobe;
      if (i < KEY_SRCS) begin : g_ks
         assign strobe = (key_idx == KIW'(i));
      end else begin : g_plain
         assign strobe = 1'b0;
      end
      if (i >= LED_BASE) begin : g_led
         always_comb begin
            if (blank)         lvl = LVL_FULL;
            else if (led_mode) lvl = led_bits[i-LED_BASE] ? LVL_FULL : LVL_GND;
            else if (in_key)   lvl = strobe ? LVL_FULL : LVL_GND;
            else               lvl = seg_level(row_bits[i], neg_pol, third_bias);
         end
      end else begin : g_lcd
         always_comb begin
            if (blank)         lvl = LVL_FULL;
            else if (in_key)   lvl = strobe ? LVL_FULL : LVL_GND;
            else               lvl = seg_level(row_bits[i], neg_pol, third_bias);
         end
      end
      assign seg_lvl[3*i +: 3] = lvl;
   end

   for (genvar k = 0; k < KEY_SRCS; k++) begin : g_ksmon
      assign ks_high[k] = (seg_lvl[3*k +: 3] == LVL_FULL);
   end

   AST_KEY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
                      (in_key && !blank && !led_mode) |-> $countones(ks_high) == 1); // R3

endmodule

// File: rtl/lcdmux_drive_seq.sv
module lcdmux_drive_seq
   import lcdseq_pkg::*;
#(
   parameter int SEG_COUNT = 56,
   parameter int KEY_SRCS  = 8,
   parameter int LED_COUNT = 8,
   parameter int KEY_SLOT  = 16,
   parameter int BASE_DIV  = 128
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [1:0]                       duty_sel,
   input  logic [1:0]                       rate_sel,
   input  logic                             disp_on,
   input  logic                             out_en,
   input  logic                             led_mode,
   input  logic [COM_COUNT*SEG_COUNT-1:0]   latch_bits,
   output logic [3*COM_COUNT-1:0]           com_lvl,
   output logic [3*SEG_COUNT-1:0]           seg_lvl
);

   localparam int KIW = (KEY_SRCS > 1) ? $clog2(KEY_SRCS) : 1;

   if (KEY_SRCS < 1 || KEY_SLOT % KEY_SRCS != 0) begin : g_bad_slot
      $error("key slot must split evenly over the key sources");
   end
   if (KEY_SLOT >= BASE_DIV) begin : g_bad_len
      $error("key slot must be shorter than the shortest phase");
   end
   if (LED_COUNT < 1 || KEY_SRCS + LED_COUNT > SEG_COUNT) begin : g_bad_map
      $error("key sources and LED pins must not overlap");
   end
   if ((BASE_DIV & (BASE_DIV - 1)) != 0) begin : g_bad_div
      $error("phase base length must be a power of two");
   end

   logic [1:0]           phase;
   logic                 neg_pol;
   logic                 in_key;
   logic [KIW-1:0]       key_idx;
   logic                 blank;
   logic                 third_bias;
   logic [SEG_COUNT-1:0] row_bits;
   logic [LED_COUNT-1:0] led_bits;

   always_comb begin
      blank      = !disp_on || !out_en;
      third_bias = !duty_sel[1];
      row_bits   = latch_bits[phase*SEG_COUNT +: SEG_COUNT];
      led_bits   = latch_bits[SEG_COUNT-1 -: LED_COUNT];
   end

   lcdseq_timer #(
      .BASE_DIV(BASE_DIV), .KEY_SLOT(KEY_SLOT), .KEY_SRCS(KEY_SRCS), .KIW(KIW)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .duty_sel(duty_sel), .rate_sel(rate_sel),
      .phase(phase), .neg_pol(neg_pol), .in_key(in_key), .key_idx(key_idx)
   );

   lcdseq_com u_com (
      .clk(clk), .rst_n(rst_n), .phase(phase), .neg_pol(neg_pol),
      .in_key(in_key), .third_bias(third_bias), .blank(blank), .com_lvl(com_lvl)
   );

   lcdseq_seg #(
      .SEG_COUNT(SEG_COUNT), .KEY_SRCS(KEY_SRCS), .LED_COUNT(LED_COUNT), .KIW(KIW)
   ) u_seg (
      .clk(clk), .rst_n(rst_n), .row_bits(row_bits), .led_bits(led_bits),
      .neg_pol(neg_pol), .in_key(in_key), .key_idx(key_idx),
      .third_bias(third_bias), .blank(blank), .led_mode(led_mode),
      .seg_lvl(seg_lvl)
   );

   AST_BLANK_ALL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
                          blank |-> (com_lvl == {COM_COUNT{LVL_FULL}} &&
                                     seg_lvl == {SEG_COUNT{LVL_FULL}})); // R8

endmodule

// File: tb/lcdmux_drive_seq_test.sv
module lcdmux_drive_seq_test;

   localparam int SEGS  = 16;
   localparam int KSRC  = 4;
   localparam int LEDS  = 4;
   localparam int KSLOT = 8;
   localparam int BASE  = 32;
   localparam int STRB  = KSLOT / KSRC;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic [1:0]          duty_sel = 2'd0;
   logic [1:0]          rate_sel = 2'd0;
   logic                disp_on = 1'b1;
   logic                out_en = 1'b1;
   logic                led_mode = 1'b0;
   logic [4*SEGS-1:0]   latch_bits = '0;
   logic [11:0]         com_lvl;
   logic [3*SEGS-1:0]   seg_lvl;

   int                  vectors = 0;
   int                  misses = 0;
   int                  t = 0;
   logic [3:0]          pmode = '0;
   int unsigned         seed_sink;

   always #2 clk = ~clk;

   lcdmux_drive_seq #(
      .SEG_COUNT(SEGS), .KEY_SRCS(KSRC), .LED_COUNT(LEDS),
      .KEY_SLOT(KSLOT), .BASE_DIV(BASE)
   ) uut (
      .clk(clk), .rst_n(rst_n), .duty_sel(duty_sel), .rate_sel(rate_sel),
      .disp_on(disp_on), .out_en(out_en), .led_mode(led_mode),
      .latch_bits(latch_bits), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
   );

   // elapsed clocks since reset or last selection change (R1)
   always @(posedge clk) begin
      if (!rst_n)                        t <= 0;
      else if ({duty_sel, rate_sel} != pmode) t <= 0;
      else                               t <= t + 1;
      pmode <= {duty_sel, rate_sel};
   end

   function automatic int ncom_of(input logic [1:0] d);
      return (d == 2'd0) ? 4 : (d == 2'd1) ? 3 : 2;
   endfunction

   function automatic int plen_of(input logic [1:0] r);
      return BASE << r;
   endfunction

   task automatic report_end();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   endtask

   task automatic one(input string tag, input string kind, input int pin,
                      input int act, input int exp);
      vectors++;
      if (act != exp) begin
         misses++;
         $display("FAIL %s %s%0d t=%0d duty=%0d rate=%0d actual=%0d expected=%0d",
                  tag, kind, pin, t, duty_sel, rate_sel, act, exp);
      end
   endtask

   task automatic check_all();
      int  plen  = plen_of(rate_sel);
      int  n     = ncom_of(duty_sel);
      int  fr    = t / (n * plen);
      int  ph    = (t % (n * plen)) / plen;
      int  c     = t % plen;
      bit  neg   = fr[0];
      bit  third = (duty_sel < 2'd2);
      bit  blnk  = !out_en || !disp_on;
      bit  key   = (c < KSLOT);
      for (int i = 0; i < 4; i++) begin
         int    e;
         string tg;
         if (blnk)           begin e = 4; tg = "R8"; end
         else if (key)       begin e = 2; tg = "R3"; end
         else begin
            if (ph == i)     e = neg ? 0 : 4;
            else if (third)  e = neg ? 3 : 1;
            else             e = 2;
            if (neg)                     tg = "R6";
            else if (fr == 0 && ph == 0) tg = "R1";
            else if (ph == n - 1)        tg = "R2";
            else                         tg = "R4";
         end
         one(tg, "com", i, int'(com_lvl[3*i +: 3]), e);
      end
      for (int i = 0; i < SEGS; i++) begin
         int    e;
         string tg;
         if (blnk) begin e = 4; tg = "R8"; end
         else if (led_mode && i >= SEGS - LEDS) begin
            e = latch_bits[i] ? 4 : 0; tg = "R7";
         end else if (key) begin
            e = (i < KSRC && (c / STRB) == i) ? 4 : 0; tg = "R3";
         end else begin
            bit lit = latch_bits[ph*SEGS + i];
            if (lit)        e = neg ? 4 : 0;
            else if (third) e = neg ? 1 : 3;
            else            e = neg ? 0 : 4;
            tg = neg ? "R6" : "R5";
         end
         one(tg, "seg", i, int'(seg_lvl[3*i +: 3]), e);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      misses++;
      $display("FAIL watchdog expired actual=hung expected=done");
      report_end();
   end

   initial begin
      seed_sink  = $urandom(32'd16431);
      latch_bits = {$urandom, $urandom};
      repeat (4) @(negedge clk);
      #1 check_all();                 // reset state, R1
      rst_n = 1'b1;
      for (int combo = 0; combo < 16; combo++) begin
         int plen, n, run;
         duty_sel = combo[3:2];
         rate_sel = combo[1:0];
         led_mode = (combo % 3 == 0);
         plen = plen_of(rate_sel);
         n    = ncom_of(duty_sel);
         run  = 2 * n * plen + 5;
         for (int k = 0; k < run; k++) begin
            @(negedge clk);
            #1 check_all();
            // blanking window inside the first frame
            if (combo % 4 == 1) out_en  = !(k >= plen - 4 && k < plen + 40);
            if (combo % 4 == 2) disp_on = !(k >= 3 && k < 30);
            if ($urandom % 32 == 0) latch_bits = {$urandom, $urandom};
            if (combo == 7 && k == plen + 1) latch_bits = '1;   // all lit
            if (combo == 8 && k == plen + 1) latch_bits = '0;   // all dark
         end
         out_en  = 1'b1;
         disp_on = 1'b1;
      end
      // duty 11 behaves as duty 10 with half bias (R2), restart mid-frame
      duty_sel = 2'd3; rate_sel = 2'd0; led_mode = 1'b1;
      for (int k = 0; k < 3 * 2 * BASE; k++) begin
         @(negedge clk);
         #1 check_all();
      end
      report_end();
   end

endmodule